// File: doc/BRIEF.md
# Cartridge PRG/CHR Bank Mapper

This block sits on the cartridge side of an 8-bit console. It watches CPU writes to the upper half of the CPU address space and keeps a small set of bank registers: two switchable 8 KiB program windows, eight 1 KiB pattern-memory slots, and a nametable mirroring selector. From these registers it turns CPU addresses into program-ROM and work-RAM addresses and picture-bus addresses into pattern-memory addresses. The memories themselves are outside the block. The block supplies only their addresses, selects and the RAM write enable.

Program memory is seen through four 8 KiB windows. The two lower windows are chosen by registers. The two upper windows are pinned to the final two banks of the ROM. Bank numbers are reduced modulo the real bank count, so ROM sizes that are not a power of two still work. Each pattern slot's 8-bit bank number is written one nibble at a time. Register decoding looks only at CPU A15..A12, A1 and A0, so every register repeats throughout its 4 KiB page.

The mirroring output is a two-state machine. `MIR_STRAP` is entered at reset, and in it the output follows a board configuration input. The transition `STRAP->LATCHED` is taken on the first mirroring write. `MIR_LATCHED` then holds the written bit. Its self-transition `LATCHED->LATCHED` reloads that bit on every later mirroring write. Only reset leaves `MIR_LATCHED`.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, every bank register is zero. The $8000–$9FFF window maps to bank 0, and every pattern slot maps to bank 0.
- R2: A write with A15..A12=4'h8 and A1:A0=2'b00 loads data bits [4:0] into the first program register. From the next cycle, CPU addresses $8000–$9FFF produce prg_rom_addr = (reg mod PRG_BANKS)*8192 + A[12:0].
- R3: A write with A15..A12=4'hA and A1:A0=2'b00 loads data bits [4:0] into the second program register. That register drives $A000–$BFFF in the same way as R2 and leaves the first register unchanged.
- R4: $C000–$DFFF always maps to bank PRG_BANKS-2, and $E000–$FFFF always maps to bank PRG_BANKS-1.
- R5: For CPU A15..A13=3'b011, prg_ram_sel is 1, prg_ram_addr=A[12:0] and prg_ram_we equals cpu_wr. prg_rom_sel equals A15, and the two selects are never both 1.
- R6: A write with A15..A12 in 4'hB..4'hE targets pattern slot 2*(A15..A12 - 4'hB) + A1. A0=0 loads the low nibble of that slot's bank number and A0=1 loads the high nibble, both from data[3:0]. The other nibble and the other slots are unchanged.
- R7: When pic_addr[13]=0, chr_sel is 1 and chr_addr = ((bank of slot pic_addr[12:10]) mod CHR_BANKS)*1024 + pic_addr[9:0]. When pic_addr[13]=1, chr_sel is 0.
- R8: mirror_horiz (1 = horizontal) follows cfg_mirror_horiz until the first write with A15..A12=4'h9 and A1:A0=2'b00. From then on it holds data bit 0 of the latest such write and ignores the configuration input.
- R9: Writes that decode to no register change no register. These are writes below $8000, writes with A15..A12=4'hF, and writes in the $8, $9 or $A pages with A1:A0 other than 2'b00.
- R10: All address outputs are combinational from the current addresses and registers, with no added cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mirror_horiz | input | 1 | Board mirroring setting used before the first mirroring write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| pic_addr | input | 14 | Picture-bus address |
| prg_rom_addr | output | PRG_AW | Program-ROM physical address |
| prg_rom_sel | output | 1 | Program-ROM select |
| prg_ram_addr | output | 13 | Work-RAM address |
| prg_ram_sel | output | 1 | Work-RAM select |
| prg_ram_we | output | 1 | Work-RAM write enable |
| chr_addr | output | CHR_AW | Pattern-memory physical address |
| chr_sel | output | 1 | Pattern-memory select |
| mirror_horiz | output | 1 | Nametable mirroring, 1 horizontal, 0 vertical |

## Verification
A wrongly latched bank register shows up at prg_rom_addr or chr_addr in the very first cycle after the write, once the bench presents an address inside the affected window. For that reason each write is followed straight away by a read of every window or slot it could have disturbed. A nibble written into the wrong slot, or into the wrong half of the right slot, changes the bank field of a neighbouring slot's address. That neighbour is therefore swept as well. A mirroring state machine stuck in the wrong state shows as mirror_horiz either following, or failing to follow, a toggle of the configuration input in the same cycle as the toggle.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    typedef enum logic {
        MIR_STRAP   = 1'b0,
        MIR_LATCHED = 1'b1
    } mir_state_e;

    typedef struct packed {
        logic [3:0] hi;
        logic [3:0] lo;
    } chr_bank_t;

    localparam int PRG_OFS_W = 13;
    localparam int CHR_OFS_W = 10;
    localparam int NUM_SLOTS = 8;
    localparam int PRG_REG_W = 5;
endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
    import cbm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_mirror_horiz,
    input  logic [15:0]              cpu_addr,
    input  logic [7:0]               cpu_wdata,
    input  logic                     cpu_wr,
    output logic [PRG_REG_W-1:0]     prg_bank0,
    output logic [PRG_REG_W-1:0]     prg_bank1,
    output chr_bank_t [NUM_SLOTS-1:0] chr_banks,
    output mir_state_e               mir_state,
    output logic                     mirror_horiz
);
    logic [3:0] page;
    logic       sub_zero;
    logic       mir_wr;
    logic [3:0] pg_off;
    logic [2:0] slot;
    logic       mir_bit;
    mir_state_e mir_next;
    logic       unused_bits;

    assign page        = cpu_addr[15:12];
    assign sub_zero    = (cpu_addr[1:0] == 2'b00);
    assign mir_wr      = cpu_wr && (page == 4'h9) && sub_zero;
    assign pg_off      = page - 4'hB;
    assign slot        = {pg_off[1:0], cpu_addr[1]};
    assign unused_bits = ^{cpu_wdata[7:5], cpu_addr[11:2], pg_off[3:2]};

    // bank registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prg_bank0 <= '0;
            prg_bank1 <= '0;
            chr_banks <= '0;
        end else if (cpu_wr) begin
            unique case (page)
                4'h8: if (sub_zero) prg_bank0 <= cpu_wdata[PRG_REG_W-1:0];
                4'hA: if (sub_zero) prg_bank1 <= cpu_wdata[PRG_REG_W-1:0];
                4'hB, 4'hC, 4'hD, 4'hE: begin
                    if (cpu_addr[0]) chr_banks[slot].hi <= cpu_wdata[3:0];
                    else             chr_banks[slot].lo <= cpu_wdata[3:0];
                end
                default: ;
            endcase
        end
    end

    // mirroring state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mir_state <= MIR_STRAP;
            mir_bit   <= 1'b0;
        end else begin
            mir_state <= mir_next;
            if (mir_wr) mir_bit <= cpu_wdata[0];
        end
    end

    // next state
    always_comb begin
        mir_next = mir_state;
        unique case (mir_state)
            MIR_STRAP:   if (mir_wr) mir_next = MIR_LATCHED;
            MIR_LATCHED: mir_next = MIR_LATCHED;
            default:     mir_next = MIR_STRAP;
        endcase
    end

    // outputs
    always_comb begin
        unique case (mir_state)
            MIR_STRAP:   mirror_horiz = cfg_mirror_horiz;
            MIR_LATCHED: mirror_horiz = mir_bit;
            default:     mirror_horiz = cfg_mirror_horiz;
        endcase
    end
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
    import cbm_pkg::*;
#(
    parameter int PRG_BANKS = 11,
    localparam int PB_W     = (PRG_BANKS > 2) ? $clog2(PRG_BANKS) : 1,
    localparam int PRG_AW   = PB_W + PRG_OFS_W
) (
    input  logic [15:0]          cpu_addr,
    input  logic                 cpu_wr,
    input  logic [PRG_REG_W-1:0] prg_bank0,
    input  logic [PRG_REG_W-1:0] prg_bank1,
    output logic [PRG_AW-1:0]    prg_rom_addr,
    output logic                 prg_rom_sel,
    output logic [PRG_OFS_W-1:0] prg_ram_addr,
    output logic                 prg_ram_sel,
    output logic                 prg_ram_we
);
    localparam logic [PB_W-1:0] BANK_LAST = PB_W'(PRG_BANKS - 1);
    localparam logic [PB_W-1:0] BANK_PREV = PB_W'(PRG_BANKS - 2);

    logic [PB_W-1:0] red0;
    logic [PB_W-1:0] red1;
    logic [PB_W-1:0] bank;

    assign red0 = PB_W'(int'(prg_bank0) % PRG_BANKS);
    assign red1 = PB_W'(int'(prg_bank1) % PRG_BANKS);

    always_comb begin
        unique case (cpu_addr[15:13])
            3'b100:  bank = red0;
            3'b101:  bank = red1;
            3'b110:  bank = BANK_PREV;
            3'b111:  bank = BANK_LAST;
            default: bank = '0;
        endcase
    end

    assign prg_rom_addr = {bank, cpu_addr[PRG_OFS_W-1:0]};
    assign prg_rom_sel  = cpu_addr[15];
    assign prg_ram_sel  = (cpu_addr[15:13] == 3'b011);
    assign prg_ram_addr = cpu_addr[PRG_OFS_W-1:0];
    assign prg_ram_we   = prg_ram_sel && cpu_wr;
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
    import cbm_pkg::*;
#(
    parameter int CHR_BANKS = 13,
    localparam int CB_W     = (CHR_BANKS > 2) ? $clog2(CHR_BANKS) : 1,
    localparam int CHR_AW   = CB_W + CHR_OFS_W
) (
    input  logic [13:0]              pic_addr,
    input  chr_bank_t [NUM_SLOTS-1:0] chr_banks,
    output logic [CHR_AW-1:0]        chr_addr,
    output logic                     chr_sel
);
    logic [CB_W-1:0] slot_red [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_red[g] = CB_W'(int'(chr_banks[g]) % CHR_BANKS);
    end

    assign chr_addr = {slot_red[pic_addr[12:10]], pic_addr[CHR_OFS_W-1:0]};
    assign chr_sel  = ~pic_addr[13];
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int PRG_BANKS = 11,
    parameter int CHR_BANKS = 13,
    localparam int PB_W     = (PRG_BANKS > 2) ? $clog2(PRG_BANKS) : 1,
    localparam int CB_W     = (CHR_BANKS > 2) ? $clog2(CHR_BANKS) : 1,
    localparam int PRG_AW   = PB_W + PRG_OFS_W,
    localparam int CHR_AW   = CB_W + CHR_OFS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_mirror_horiz,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_wdata,
    input  logic                 cpu_wr,
    input  logic [13:0]          pic_addr,
    output logic [PRG_AW-1:0]    prg_rom_addr,
    output logic                 prg_rom_sel,
    output logic [PRG_OFS_W-1:0] prg_ram_addr,
    output logic                 prg_ram_sel,
    output logic                 prg_ram_we,
    output logic [CHR_AW-1:0]    chr_addr,
    output logic                 chr_sel,
    output logic                 mirror_horiz
);
    logic [PRG_REG_W-1:0]     prg_bank0;
    logic [PRG_REG_W-1:0]     prg_bank1;
    chr_bank_t [NUM_SLOTS-1:0] chr_banks;
    mir_state_e               mir_state;

    cbm_regs u_regs (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_mirror_horiz (cfg_mirror_horiz),
        .cpu_addr         (cpu_addr),
        .cpu_wdata        (cpu_wdata),
        .cpu_wr           (cpu_wr),
        .prg_bank0        (prg_bank0),
        .prg_bank1        (prg_bank1),
        .chr_banks        (chr_banks),
        .mir_state        (mir_state),
        .mirror_horiz     (mirror_horiz)
    );

    cbm_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .cpu_addr     (cpu_addr),
        .cpu_wr       (cpu_wr),
        .prg_bank0    (prg_bank0),
        .prg_bank1    (prg_bank1),
        .prg_rom_addr (prg_rom_addr),
        .prg_rom_sel  (prg_rom_sel),
        .prg_ram_addr (prg_ram_addr),
        .prg_ram_sel  (prg_ram_sel),
        .prg_ram_we   (prg_ram_we)
    );

    cbm_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
        .pic_addr  (pic_addr),
        .chr_banks (chr_banks),
        .chr_addr  (chr_addr),
        .chr_sel   (chr_sel)
    );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker
    import cbm_pkg::*;
#(
    parameter int PRG_BANKS = 11,
    parameter int CHR_BANKS = 13,
    localparam int PB_W     = (PRG_BANKS > 2) ? $clog2(PRG_BANKS) : 1,
    localparam int CB_W     = (CHR_BANKS > 2) ? $clog2(CHR_BANKS) : 1,
    localparam int PRG_AW   = PB_W + PRG_OFS_W,
    localparam int CHR_AW   = CB_W + CHR_OFS_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [15:0]          cpu_addr,
    input logic [7:0]           cpu_wdata,
    input logic                 cpu_wr,
    input logic [PRG_REG_W-1:0] prg_bank0,
    input logic [PRG_REG_W-1:0] prg_bank1,
    input mir_state_e           mir_state,
    input logic                 mirror_horiz,
    input logic                 prg_rom_sel,
    input logic                 prg_ram_sel,
    input logic [PRG_AW-1:0]    prg_rom_addr,
    input logic [CHR_AW-1:0]    chr_addr
);
    p_load_bank0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:12] == 4'h8 && cpu_addr[1:0] == 2'b00)
        |=> (prg_bank0 == $past(cpu_wdata[PRG_REG_W-1:0])));

    p_load_bank1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:12] == 4'hA && cpu_addr[1:0] == 2'b00)
        |=> (prg_bank1 == $past(cpu_wdata[PRG_REG_W-1:0]) && $stable(prg_bank0)));

    p_fixed_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (prg_rom_addr[PRG_AW-1:PRG_OFS_W] == PB_W'(PRG_BANKS - 1)));

    p_fixed_prev_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b110) |-> (prg_rom_addr[PRG_AW-1:PRG_OFS_W] == PB_W'(PRG_BANKS - 2)));

    p_sel_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prg_rom_sel, prg_ram_sel}));

    p_chr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chr_addr[CHR_AW-1:CHR_OFS_W]) < CHR_BANKS);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_state == MIR_LATCHED) |=> (mir_state == MIR_LATCHED));

    p_mirror_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_state == MIR_LATCHED && !(cpu_wr && cpu_addr[15:12] == 4'h9 && cpu_addr[1:0] == 2'b00))
        |=> $stable(mirror_horiz));

    p_top_page_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:12] == 4'hF) |=> ($stable(prg_bank0) && $stable(prg_bank1)));
endmodule

bind cart_bank_mapper cbm_checker #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_wr       (cpu_wr),
    .prg_bank0    (prg_bank0),
    .prg_bank1    (prg_bank1),
    .mir_state    (mir_state),
    .mirror_horiz (mirror_horiz),
    .prg_rom_sel  (prg_rom_sel),
    .prg_ram_sel  (prg_ram_sel),
    .prg_rom_addr (prg_rom_addr),
    .chr_addr     (chr_addr)
);

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
    localparam int NPB = 11;
    localparam int NCB = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mirror_horiz = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [13:0] pic_addr = 14'h0000;
    logic [16:0] prg_rom_addr;
    logic        prg_rom_sel;
    logic [12:0] prg_ram_addr;
    logic        prg_ram_sel;
    logic        prg_ram_we;
    logic [13:0] chr_addr;
    logic        chr_sel;
    logic        mirror_horiz;

    int total = 0;
    int bad = 0;
    int lo_n [8];
    int hi_n [8];

    always #5 clk = ~clk;

    cart_bank_mapper #(.PRG_BANKS(NPB), .CHR_BANKS(NCB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mirror_horiz(cfg_mirror_horiz),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
        .pic_addr(pic_addr), .prg_rom_addr(prg_rom_addr), .prg_rom_sel(prg_rom_sel),
        .prg_ram_addr(prg_ram_addr), .prg_ram_sel(prg_ram_sel), .prg_ram_we(prg_ram_we),
        .chr_addr(chr_addr), .chr_sel(chr_sel), .mirror_horiz(mirror_horiz)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic prg_probe(input string req, input logic [15:0] a, input int exp);
        cpu_addr = a;
        #2;
        chk(req, int'(prg_rom_addr), exp);
    endtask

    task automatic chr_probe(input string req, input logic [13:0] p, input int exp);
        pic_addr = p;
        #2;
        chk(req, int'(chr_addr), exp);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        prg_probe("R1", 16'h8123, 16'h0123);
        for (int s = 0; s < 8; s++)
            chr_probe("R1", 14'(s * 1024 + 5), 5);
        // R10 combinational response, no clock edge between address and sample
        prg_probe("R10", 16'hE7FF, (NPB - 1) * 8192 + 16'h07FF);

        // R2 / R3 sweep of all 5-bit bank values; aliased offsets
        for (int v = 0; v < 32; v++) begin
            int off = (v * 97) & 16'h1FFF;
            wr(16'h8000 | 16'(((v * 4) & 16'h0FFC)), 8'(v | 8'hE0));
            prg_probe("R2", 16'(16'h8000 + off), (v % NPB) * 8192 + off);
            wr(16'hA00C, 8'((31 - v) | 8'h60));
            prg_probe("R3", 16'(16'hA000 + off), ((31 - v) % NPB) * 8192 + off);
            prg_probe("R3", 16'(16'h8000 + off), (v % NPB) * 8192 + off);
        end
        // bank0 now 31%11=9, bank1 0
        // R4 fixed windows
        prg_probe("R4", 16'hC000, (NPB - 2) * 8192);
        prg_probe("R4", 16'hDFFF, (NPB - 2) * 8192 + 16'h1FFF);
        prg_probe("R4", 16'hF456, (NPB - 1) * 8192 + 16'h1456);

        // R5 work RAM
        cpu_addr = 16'h6ABC; #2;
        chk("R5", {prg_ram_sel, prg_rom_sel, prg_ram_we}, 3'b100);
        chk("R5", int'(prg_ram_addr), 16'h0ABC);
        @(negedge clk);
        cpu_wr = 1'b1; #2;
        chk("R5", int'(prg_ram_we), 1);
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_addr = 16'h9000; #2;
        chk("R5", {prg_ram_sel, prg_rom_sel}, 2'b01);

        // R9 ignored writes
        wr(16'h8001, 8'h03);
        wr(16'h8002, 8'h04);
        wr(16'hF000, 8'h1F);
        wr(16'h7000, 8'h05);
        wr(16'hA003, 8'h02);
        prg_probe("R9", 16'h8010, 9 * 8192 + 16'h10);
        prg_probe("R9", 16'hA010, 16'h10);

        // R6 / R7 pattern slots
        for (int s = 0; s < 8; s++) begin
            logic [15:0] base;
            base = 16'(16'hB000 + (s / 2) * 16'h1000 + (s % 2) * 2);
            lo_n[s] = (s * 5 + 3) & 15;
            hi_n[s] = (s * 3 + 1) & 15;
            wr(base, 8'(lo_n[s] | 8'hF0));
            wr(base | 16'h0001, 8'(hi_n[s] | 8'hA0));
        end
        for (int s = 0; s < 8; s++)
            chr_probe("R7", 14'(s * 1024 + s * 37),
                      ((hi_n[s] * 16 + lo_n[s]) % NCB) * 1024 + s * 37);
        // low nibble only of slot 5 (page D, A1=1), aliased address
        wr(16'hD4F2, 8'h0E);
        lo_n[5] = 14;
        for (int s = 0; s < 8; s++)
            chr_probe("R6", 14'(s * 1024 + 3),
                      ((hi_n[s] * 16 + lo_n[s]) % NCB) * 1024 + 3);
        pic_addr = 14'h2000; #2;
        chk("R7", int'(chr_sel), 0);
        pic_addr = 14'h1FFF; #2;
        chk("R7", int'(chr_sel), 1);

        // R8 mirroring state machine
        cfg_mirror_horiz = 1'b0; #2;
        chk("R8", int'(mirror_horiz), 0);
        cfg_mirror_horiz = 1'b1; #2;
        chk("R8", int'(mirror_horiz), 1);
        wr(16'h9001, 8'h00);
        wr(16'hF000, 8'h00);
        chk("R9", int'(mirror_horiz), 1);
        wr(16'h9ABC, 8'hFE);
        chk("R8", int'(mirror_horiz), 0);
        cfg_mirror_horiz = 1'b0; #2;
        chk("R8", int'(mirror_horiz), 0);
        cfg_mirror_horiz = 1'b1; #2;
        chk("R8", int'(mirror_horiz), 0);
        wr(16'h9000, 8'h01);
        cfg_mirror_horiz = 1'b0; #2;
        chk("R8", int'(mirror_horiz), 1);
        wr(16'h9002, 8'h00);
        chk("R9", int'(mirror_horiz), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule